// File: doc/BRIEF.md
# Saved-Context Readout Register Bank

This block sits between a block-cipher core and a simple register bus. When the core finishes an operation that has context saving enabled, it pulses a completion strobe carrying the final chaining value (IV or counter) and the authentication tag. The bank captures both values and raises a context-ready flag. Software sees this flag in a status word. It then reads the tag and the IV as four 32-bit words each.

A read of the highest word of either group clears the flag. While the flag is set, the bank holds off the core's request to start a new operation. Software therefore has to drain the saved context before the next operation can run. For chaining modes without authentication, software polls the flag and then reads the IV words. For authenticated modes it reads the tag first and the IV after it.

The IV word addresses can also be written, to load the starting vector before an operation. The loaded vector is driven to the core continuously. A synchronous soft-reset input clears all captured state in one cycle.

Top module: `ctx_readout_regs`

## Requirements
- R1: After reset the ready flag is 0, start_ok equals start_req, and every readable word returns 0.
- R2: A cycle with done_strobe and save_en both high captures done_iv and done_tag, and the ready flag is 1 from the next cycle. A strobe with save_en low changes neither the flag nor the stored words.
- R3: Word address 0 is the status word. Bit 0 holds the ready flag and all other bits read 0.
- R4: The IV words sit at word addresses 4 to 7 and the tag words at 8 to 11. Word k holds bits [32k+31:32k] of its 128-bit value. Unmapped addresses read 0.
- R5: A read of address 7 (IV word 3) or address 11 (tag word 3) clears the ready flag at the clock edge that ends the read. The read itself returns the stored word.
- R6: Reads of every other address leave the ready flag and all stored words unchanged, and they may be repeated.
- R7: start_ok is 0 while the ready flag is set, whatever start_req is. While the flag is clear, start_ok follows start_req.
- R8: A write to addresses 4 to 7 loads that IV word, which then reads back and appears on iv_to_core. Writes to any other address have no effect.
- R9: When a capture and a clearing read fall in the same cycle, the capture wins and the flag stays 1.
- R10: soft_rst clears the ready flag, all IV words and all tag words at the next edge.
- R11: A read of address 7 or 11 while the flag is already clear returns the stored word and changes nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of the flag and all stored words |
| done_strobe | input | 1 | Core completion pulse |
| save_en | input | 1 | Context saving enabled for the completing operation |
| done_iv | input | 128 | Final IV or counter from the core |
| done_tag | input | 128 | Authentication tag from the core |
| start_req | input | 1 | Core asks to begin an operation |
| start_ok | output | 1 | Start permitted to the core |
| ctx_ready | output | 1 | Saved-context-ready flag |
| iv_to_core | output | 128 | Current IV register contents |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |

## Verification
The bench builds the bank with its default parameters: 32-bit words, four words per group, a 4-bit address, and the status, IV and tag groups at addresses 0, 4 and 8. With these values every mapped word and the unmapped gaps between the groups can be reached. The bench covers a clearing read from each group. It also drives the capture and a clearing read in the same cycle, and a completion strobe that arrives without context saving.

// File: rtl/ctx_readout_regs.sv
module ctx_readout_regs #(
  parameter int WORD_W   = 32,
  parameter int NWORDS   = 4,
  parameter int ADDR_W   = 4,
  parameter int STAT_ADR = 0,
  parameter int IV_BASE  = 4,
  parameter int TAG_BASE = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     soft_rst,
  input  logic                     done_strobe,
  input  logic                     save_en,
  input  logic [WORD_W*NWORDS-1:0] done_iv,
  input  logic [WORD_W*NWORDS-1:0] done_tag,
  input  logic                     start_req,
  output logic                     start_ok,
  output logic                     ctx_ready,
  output logic [WORD_W*NWORDS-1:0] iv_to_core,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [WORD_W-1:0]        bus_wdata,
  output logic [WORD_W-1:0]        bus_rdata
);
  localparam logic [ADDR_W-1:0] IV_LAST  = ADDR_W'(IV_BASE + NWORDS - 1);
  localparam logic [ADDR_W-1:0] TAG_LAST = ADDR_W'(TAG_BASE + NWORDS - 1);
  localparam logic [ADDR_W-1:0] STAT_A   = ADDR_W'(STAT_ADR);

  logic [WORD_W-1:0] iv_q  [NWORDS];
  logic [WORD_W-1:0] tag_q [NWORDS];
  logic capture, drain_rd;

  assign capture  = done_strobe & save_en;
  assign drain_rd = bus_rd & ((bus_addr == IV_LAST) | (bus_addr == TAG_LAST));
  assign start_ok = start_req & ~ctx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctx_ready <= 1'b0;
    else if (soft_rst) ctx_ready <= 1'b0;
    else if (capture)  ctx_ready <= 1'b1;
    else if (drain_rd) ctx_ready <= 1'b0;
  end

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    localparam logic [ADDR_W-1:0] IV_A = ADDR_W'(IV_BASE + i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        iv_q[i]  <= '0;
        tag_q[i] <= '0;
      end else if (soft_rst) begin
        iv_q[i]  <= '0;
        tag_q[i] <= '0;
      end else if (capture) begin
        iv_q[i]  <= done_iv[i*WORD_W +: WORD_W];
        tag_q[i] <= done_tag[i*WORD_W +: WORD_W];
      end else if (bus_wr && bus_addr == IV_A) begin
        iv_q[i]  <= bus_wdata;
      end
    end

    assign iv_to_core[i*WORD_W +: WORD_W] = iv_q[i];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == STAT_A) bus_rdata = {{(WORD_W-1){1'b0}}, ctx_ready};
    for (int i = 0; i < NWORDS; i++) begin
      if (bus_addr == ADDR_W'(IV_BASE + i))  bus_rdata = iv_q[i];
      if (bus_addr == ADDR_W'(TAG_BASE + i)) bus_rdata = tag_q[i];
    end
  end

  a_r2_capture_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !soft_rst) |=> ctx_ready);
  a_r2_rise_needs_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctx_ready) |-> $past(done_strobe && save_en));
  a_r5_drain_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_rd && !capture) |=> !ctx_ready);
  a_r6_side_free_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!drain_rd && !done_strobe && !soft_rst) |=> $stable(ctx_ready));
  a_r7_hold_start: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_ready && start_req) |-> !start_ok);
  a_r10_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!ctx_ready && iv_to_core == '0));
endmodule

// File: tb/sim_ctx_readout_regs.sv
module sim_ctx_readout_regs;
  logic clk = 0, rst_n = 0, soft_rst = 0, done_strobe = 0, save_en = 0;
  logic [127:0] done_iv = '0, done_tag = '0;
  logic start_req = 0, start_ok, ctx_ready;
  logic [127:0] iv_to_core;
  logic bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  ctx_readout_regs u0 (.*);

  // op: 0 write, 1 read+check, 2 capture with seed
  localparam int NV = 16;
  localparam logic [69:0] VEC [NV] = '{
    {2'd0, 4'd4,  32'h11111111, 32'h0},
    {2'd0, 4'd7,  32'h44444444, 32'h0},
    {2'd1, 4'd4,  32'h0, 32'h11111111},
    {2'd1, 4'd7,  32'h0, 32'h44444444},
    {2'd1, 4'd0,  32'h0, 32'h0},
    {2'd2, 4'd0,  32'h100, 32'h0},
    {2'd1, 4'd0,  32'h0, 32'h1},
    {2'd1, 4'd8,  32'h0, 32'hFFFFFEFF},
    {2'd1, 4'd9,  32'h0, 32'hFFFFFEFE},
    {2'd1, 4'd10, 32'h0, 32'hFFFFFEFD},
    {2'd1, 4'd0,  32'h0, 32'h1},
    {2'd1, 4'd11, 32'h0, 32'hFFFFFEFC},
    {2'd1, 4'd0,  32'h0, 32'h0},
    {2'd1, 4'd5,  32'h0, 32'h101},
    {2'd0, 4'd2,  32'h0000DEAD, 32'h0},
    {2'd1, 4'd2,  32'h0, 32'h0}
  };

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [31:0] seed, input logic sv);
    done_iv  = {seed + 32'd3, seed + 32'd2, seed + 32'd1, seed};
    done_tag = ~done_iv;
    done_strobe = 1; save_en = sv;
  endtask

  task automatic idle();
    bus_wr = 0; bus_rd = 0; done_strobe = 0; save_en = 0; soft_rst = 0;
  endtask

  task automatic step();
    @(posedge clk); #1 idle();
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1;
    check(req, {96'd0, bus_rdata}, {96'd0, exp});
    step();
  endtask

  initial begin
    #40000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #9 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 ready", {127'd0, ctx_ready}, 128'd0);
    start_req = 1; #1;
    check("R1 start_ok", {127'd0, start_ok}, 128'd1);
    start_req = 0;
    rd(4'd9, 32'd0, "R1 tag word");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      bus_addr = VEC[i][67:64];
      case (VEC[i][69:68])
        2'd0: begin bus_wdata = VEC[i][63:32]; bus_wr = 1; end
        2'd2: load(VEC[i][63:32], 1'b1);
        default: begin
          bus_rd = 1; #1;
          check($sformatf("R3/R4/R5/R6/R8/R11 vec %0d", i), {96'd0, bus_rdata}, {96'd0, VEC[i][31:0]});
        end
      endcase
      step();
    end

    // R8 iv_to_core reflects writes and capture
    @(negedge clk);
    check("R8 iv_to_core", iv_to_core, {32'h103, 32'h102, 32'h101, 32'h100});

    // R2 strobe without save_en
    @(negedge clk); load(32'h500, 1'b0); step();
    rd(4'd0, 32'd0, "R2 no-save flag");
    rd(4'd4, 32'h100, "R2 no-save iv");

    // R7 start held while ready
    @(negedge clk); load(32'h200, 1'b1); step();
    @(negedge clk); start_req = 1; #1;
    check("R7 held", {127'd0, start_ok}, 128'd0);
    // R9 capture and drain read together
    bus_addr = 4'd7; bus_rd = 1; load(32'h300, 1'b1); step();
    @(negedge clk); #1;
    check("R9 flag kept", {127'd0, ctx_ready}, 128'd1);
    rd(4'd7, 32'h303, "R5 iv word3 drain");
    @(negedge clk); #1;
    check("R7 released", {127'd0, start_ok}, 128'd1);
    start_req = 0;

    // R10 soft reset
    @(negedge clk); load(32'h400, 1'b1); step();
    @(negedge clk); soft_rst = 1; step();
    @(negedge clk);
    check("R10 flag", {127'd0, ctx_ready}, 128'd0);
    check("R10 iv", iv_to_core, 128'd0);
    rd(4'd10, 32'd0, "R10 tag");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule